// File: doc/BRIEF.md
# CPU Address Decode Window Unit

This block holds a bank of programmable windows that steer CPU physical addresses to device targets. Each window has a control word (enable, 4-bit target, 8-bit attribute and a size mask in 64 KiB units) and a base word. The low-numbered windows also carry a remap pair that rewrites the upper address bits on the way to the device. Software programs the windows through a 32-bit register port. Each read returns its data one cycle after the strobe.

The decode port takes a 32-bit CPU address with a request strobe. One cycle later it reports whether a window matched, along with that window's target and attribute and the 36-bit translated device address. When several windows match, the lowest-numbered window wins. A write to a window's base register also loads that value into its remap pair, if the window has one. Translation is therefore the identity until software writes the remap registers.

Top module: `addr_window_unit`

## Requirements
- R1: After reset every window is disabled, all register reads return 0 and every decode request misses.
- R2: Window n below NUM_REMAP (8) sits at byte offset n*16 with control at +0, base at +4, remap low at +8 and remap high at +12. Window n of NUM_REMAP or more has control at 0x90+(n-8)*8 and base at +4. A read strobe returns its word on `reg_rdata` in the following cycle, and the value holds until the next read.
- R3: Control fields are bit 0 enable, bits 7:4 target, bits 15:8 attribute and bits 31:16 size mask. Bits 3:1 always read as 0.
- R4: Base keeps bits 31:16 (address bits 31:16) and bits 3:0 (address bits 35:32), and all other bits read 0. Remap low keeps only bits 31:16. Remap high keeps only bits 3:0.
- R5: Writing the base of a window below NUM_REMAP also loads its remap low and remap high with the same fields. A later remap write overrides them.
- R6: A request hits a window when the window is enabled, its base bits 35:32 are zero, and (addr AND NOT mask) equals the base bits 31:16 followed by 16 zero bits, where mask = {size field, 16'hFFFF}. The result appears with `dec_vld` one cycle after `dec_req`.
- R7: For a window below NUM_REMAP the translated address is {remap high, (remap low<<16 AND NOT mask) OR (addr AND mask)}. For any other window it is {4'h0, addr}.
- R8: When several windows hit, the lowest-numbered one supplies target, attribute and translation.
- R9: On a miss, `dec_hit`, `dec_tgt`, `dec_attr` and `dec_xlat` are all 0.
- R10: Offsets that map to no register read as 0 and ignore writes. These are the hole 0x80-0x8F, offsets at or above 0xF0, and any offset with bits 1:0 not zero.
- R11: A window with enable 0 never hits, even when its base matches.
- R12: A register write and a decode request in the same cycle: the decode uses the window state from before the write. A read and a write to the same register in the same cycle: the read returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_off | input | OFF_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, updated the cycle after `reg_rd` |
| dec_req | input | 1 | Decode request strobe |
| dec_addr | input | 32 | CPU address to decode |
| dec_vld | output | 1 | Decode result valid |
| dec_hit | output | 1 | A window matched |
| dec_tgt | output | 4 | Target of the winning window |
| dec_attr | output | 8 | Attribute of the winning window |
| dec_xlat | output | 36 | Translated device address |

## Verification
Two functions can coincide in one cycle: a register write that changes a window, and a decode request for an address that window covers. The bench provokes this by asserting `reg_wr` (enabling a window) and `dec_req` (for an address inside it) on the same clock edge. The scoreboard expects a miss for that request and a hit for an identical request one cycle later. The same idea is applied to the register port: a read and a write strobe to one control register in the same cycle must return the pre-write word.

// File: rtl/awu_pkg.sv
package awu_pkg;

    // Window control fields
    typedef struct packed {
        logic [15:0] szm;   // size-1 in 64 KiB units, used as a mask
        logic [7:0]  attr;
        logic [3:0]  tgt;
        logic        en;
    } win_ctrl_t;

    // 36-bit address held as bits 31:16 and bits 35:32
    typedef struct packed {
        logic [15:0] lo;
        logic [3:0]  hi;
    } addr36_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_BASE,
        SEL_RMP_LO,
        SEL_RMP_HI
    } reg_sel_e;

    typedef struct packed {
        logic        vld;
        logic        hit;
        logic [3:0]  tgt;
        logic [7:0]  attr;
        logic [35:0] xlat;
    } dec_out_t;

    function automatic logic [31:0] a36_to_word(input addr36_t a);
        return {a.lo, 12'h000, a.hi};
    endfunction

    function automatic logic [31:0] ctrl_to_word(input win_ctrl_t c);
        return {c.szm, c.attr, c.tgt, 3'b000, c.en};
    endfunction

endpackage

// File: rtl/awu_off_dec.sv
module awu_off_dec
    import awu_pkg::*;
#(
    parameter int NUM_WIN   = 20,
    parameter int NUM_REMAP = 8,
    parameter int OFF_W     = 8,
    localparam int IDX_W    = $clog2(NUM_WIN)
) (
    input  logic [OFF_W-1:0] off_i,
    output reg_sel_e         sel_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam int LO_SPAN  = NUM_REMAP * 16;
    localparam int HI_START = LO_SPAN + 16;
    localparam int HI_END   = HI_START + (NUM_WIN - NUM_REMAP) * 8;

    always_comb begin
        int off_v;
        int rel_v;
        off_v = int'(off_i);
        rel_v = off_v - HI_START;
        sel_o = SEL_NONE;
        idx_o = '0;
        if (off_i[1:0] == 2'b00) begin
            if (off_v < LO_SPAN) begin
                idx_o = IDX_W'(off_v / 16);
                case (off_i[3:2])
                    2'd0:    sel_o = SEL_CTRL;
                    2'd1:    sel_o = SEL_BASE;
                    2'd2:    sel_o = SEL_RMP_LO;
                    default: sel_o = SEL_RMP_HI;
                endcase
            end else if (off_v >= HI_START && off_v < HI_END) begin
                idx_o = IDX_W'(NUM_REMAP + rel_v / 8);
                sel_o = off_i[2] ? SEL_BASE : SEL_CTRL;
            end
        end
    end

endmodule

// File: rtl/awu_regfile.sv
module awu_regfile
    import awu_pkg::*;
#(
    parameter int NUM_WIN   = 20,
    parameter int NUM_REMAP = 8,
    parameter int OFF_W     = 8,
    localparam int IDX_W    = $clog2(NUM_WIN),
    localparam int RIDX_W   = (NUM_REMAP > 1) ? $clog2(NUM_REMAP) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_i,
    input  logic                          rd_i,
    input  logic [OFF_W-1:0]              off_i,
    input  logic [31:0]                   wdata_i,
    output logic [31:0]                   rdata_o,
    output win_ctrl_t [NUM_WIN-1:0]       ctrl_o,
    output addr36_t   [NUM_WIN-1:0]       base_o,
    output addr36_t   [NUM_REMAP-1:0]     rmp_o
);
    typedef struct packed {
        win_ctrl_t [NUM_WIN-1:0]   ctrl;
        addr36_t   [NUM_WIN-1:0]   base;
        addr36_t   [NUM_REMAP-1:0] rmp;
        logic [31:0]               rdata;
    } rf_t;

    rf_t st_d, st_q;

    reg_sel_e          sel;
    logic [IDX_W-1:0]  idx;
    logic [RIDX_W-1:0] ridx;
    logic              is_rmp_win;

    awu_off_dec #(
        .NUM_WIN   (NUM_WIN),
        .NUM_REMAP (NUM_REMAP),
        .OFF_W     (OFF_W)
    ) u_off_dec (
        .off_i (off_i),
        .sel_o (sel),
        .idx_o (idx)
    );

    assign ridx       = RIDX_W'(idx);
    assign is_rmp_win = (int'(idx) < NUM_REMAP);

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            case (sel)
                SEL_CTRL: begin
                    st_d.ctrl[idx].en   = wdata_i[0];
                    st_d.ctrl[idx].tgt  = wdata_i[7:4];
                    st_d.ctrl[idx].attr = wdata_i[15:8];
                    st_d.ctrl[idx].szm  = wdata_i[31:16];
                end
                SEL_BASE: begin
                    st_d.base[idx].lo = wdata_i[31:16];
                    st_d.base[idx].hi = wdata_i[3:0];
                    if (is_rmp_win) begin
                        st_d.rmp[ridx].lo = wdata_i[31:16];
                        st_d.rmp[ridx].hi = wdata_i[3:0];
                    end
                end
                SEL_RMP_LO: st_d.rmp[ridx].lo = wdata_i[31:16];
                SEL_RMP_HI: st_d.rmp[ridx].hi = wdata_i[3:0];
                default: ;
            endcase
        end
        if (rd_i) begin
            case (sel)
                SEL_CTRL:   st_d.rdata = ctrl_to_word(st_q.ctrl[idx]);
                SEL_BASE:   st_d.rdata = a36_to_word(st_q.base[idx]);
                SEL_RMP_LO: st_d.rdata = {st_q.rmp[ridx].lo, 16'h0000};
                SEL_RMP_HI: st_d.rdata = {28'h0, st_q.rmp[ridx].hi};
                default:    st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;
    assign ctrl_o  = st_q.ctrl;
    assign base_o  = st_q.base;
    assign rmp_o   = st_q.rmp;

    // Reads of offsets with no register come back as zero
    assert_unimpl_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && sel == SEL_NONE) |=> (rdata_o == 32'h0));

    // Control reserved bits never read back as set
    assert_ctrl_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && sel == SEL_CTRL) |=> (rdata_o[3:1] == 3'b000));

    // A base write on a remappable window leaves remap equal to base
    assert_base_copies_remap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel == SEL_BASE && is_rmp_win) |=> (rmp_o[$past(ridx)] == base_o[$past(idx)]));

    // Writes that land on no register change no window state
    assert_unimpl_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel == SEL_NONE) |=> ($stable(ctrl_o) && $stable(base_o) && $stable(rmp_o)));

endmodule

// File: rtl/awu_match.sv
module awu_match
    import awu_pkg::*;
#(
    parameter int NUM_WIN   = 20,
    parameter int NUM_REMAP = 8
) (
    input  logic [31:0]                   addr_i,
    input  win_ctrl_t [NUM_WIN-1:0]       ctrl_i,
    input  addr36_t   [NUM_WIN-1:0]       base_i,
    input  addr36_t   [NUM_REMAP-1:0]     rmp_i,
    output logic [NUM_WIN-1:0]            hit_o,
    output logic [NUM_WIN-1:0][35:0]      xlat_o
);
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        logic [31:0] mask;
        assign mask     = {ctrl_i[w].szm, 16'hFFFF};
        assign hit_o[w] = ctrl_i[w].en && (base_i[w].hi == 4'h0) &&
                          ((addr_i & ~mask) == {base_i[w].lo, 16'h0000});
        if (w < NUM_REMAP) begin : g_rmp
            assign xlat_o[w] = {rmp_i[w].hi,
                                ({rmp_i[w].lo, 16'h0000} & ~mask) | (addr_i & mask)};
        end else begin : g_pass
            assign xlat_o[w] = {4'h0, addr_i};
        end
    end

endmodule

// File: rtl/awu_prio.sv
module awu_prio #(
    parameter int N = 20
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o
);
    always_comb begin
        gnt_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                gnt_o    = '0;
                gnt_o[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/addr_window_unit.sv
module addr_window_unit
    import awu_pkg::*;
#(
    parameter int NUM_WIN   = 20,
    parameter int NUM_REMAP = 8,
    parameter int OFF_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [OFF_W-1:0] reg_off,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             dec_req,
    input  logic [31:0]      dec_addr,
    output logic             dec_vld,
    output logic             dec_hit,
    output logic [3:0]       dec_tgt,
    output logic [7:0]       dec_attr,
    output logic [35:0]      dec_xlat
);
    win_ctrl_t [NUM_WIN-1:0]   ctrl;
    addr36_t   [NUM_WIN-1:0]   base;
    addr36_t   [NUM_REMAP-1:0] rmp;
    logic [NUM_WIN-1:0]        hit_vec;
    logic [NUM_WIN-1:0]        gnt;
    logic [NUM_WIN-1:0]        en_vec;
    logic [NUM_WIN-1:0][35:0]  xlat_vec;

    dec_out_t out_d, out_q;

    awu_regfile #(
        .NUM_WIN   (NUM_WIN),
        .NUM_REMAP (NUM_REMAP),
        .OFF_W     (OFF_W)
    ) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .rd_i    (reg_rd),
        .off_i   (reg_off),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .ctrl_o  (ctrl),
        .base_o  (base),
        .rmp_o   (rmp)
    );

    awu_match #(
        .NUM_WIN   (NUM_WIN),
        .NUM_REMAP (NUM_REMAP)
    ) u_match (
        .addr_i (dec_addr),
        .ctrl_i (ctrl),
        .base_i (base),
        .rmp_i  (rmp),
        .hit_o  (hit_vec),
        .xlat_o (xlat_vec)
    );

    awu_prio #(
        .N (NUM_WIN)
    ) u_prio (
        .req_i (hit_vec),
        .gnt_o (gnt)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_en
        assign en_vec[w] = ctrl[w].en;
    end

    always_comb begin
        out_d     = '0;
        out_d.vld = dec_req;
        if (dec_req) begin
            out_d.hit = |gnt;
            for (int w = 0; w < NUM_WIN; w++) begin
                if (gnt[w]) begin
                    out_d.tgt  = out_d.tgt  | ctrl[w].tgt;
                    out_d.attr = out_d.attr | ctrl[w].attr;
                    out_d.xlat = out_d.xlat | xlat_vec[w];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign dec_vld  = out_q.vld;
    assign dec_hit  = out_q.hit;
    assign dec_tgt  = out_q.tgt;
    assign dec_attr = out_q.attr;
    assign dec_xlat = out_q.xlat;

    assert_resp_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_req |=> dec_vld);

    assert_no_spurious_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_req |=> !dec_vld);

    assert_single_winner_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    assert_disabled_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~en_vec) == '0);

    assert_miss_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && !dec_hit) |-> (dec_tgt == 4'h0 && dec_attr == 8'h00 && dec_xlat == 36'h0));

endmodule

// File: tb/tb_addr_window_unit.sv
module tb_addr_window_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_off = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dec_req = 1'b0;
    logic [31:0] dec_addr = '0;
    logic        dec_vld;
    logic        dec_hit;
    logic [3:0]  dec_tgt;
    logic [7:0]  dec_attr;
    logic [35:0] dec_xlat;

    always #2 clk = ~clk;   // 250 MHz

    addr_window_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_off   (reg_off),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .dec_req   (dec_req),
        .dec_addr  (dec_addr),
        .dec_vld   (dec_vld),
        .dec_hit   (dec_hit),
        .dec_tgt   (dec_tgt),
        .dec_attr  (dec_attr),
        .dec_xlat  (dec_xlat)
    );

    typedef struct {
        logic        hit;
        logic [3:0]  tgt;
        logic [7:0]  attr;
        logic [35:0] xlat;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] off, input logic [31:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_off = off; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [7:0] off, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_rd = 1'b1; reg_off = off;
        @(negedge clk);
        reg_rd = 1'b0;
        check32(req, reg_rdata, exp);
    endtask

    function automatic exp_t mk(input logic h, input logic [3:0] t, input logic [7:0] a,
                                input logic [35:0] x, input string req);
        exp_t e;
        e.hit = h; e.tgt = t; e.attr = a; e.xlat = x; e.req = req;
        return e;
    endfunction

    task automatic do_dec(input logic [31:0] addr, input exp_t e);
        @(negedge clk);
        dec_req = 1'b1; dec_addr = addr;
        exp_q.push_back(e);
        @(negedge clk);
        dec_req = 1'b0;
    endtask

    // Monitor: pop and compare each decode result
    always @(negedge clk) begin
        if (rst_n && dec_vld) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R6: unexpected result hit=%b tgt=%h, expected none", dec_hit, dec_tgt);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (dec_hit !== e.hit || dec_tgt !== e.tgt || dec_attr !== e.attr || dec_xlat !== e.xlat) begin
                    n_bad++;
                    $display("FAIL %s: actual hit=%b tgt=%h attr=%h xlat=%h expected hit=%b tgt=%h attr=%h xlat=%h",
                             e.req, dec_hit, dec_tgt, dec_attr, dec_xlat, e.hit, e.tgt, e.attr, e.xlat);
                end
            end
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        do_rd(8'h00, 32'h0, "R1 ctrl w0");
        do_rd(8'hA4, 32'h0, "R1 base w10");
        do_dec(32'h1234_5678, mk(0, 0, 0, 0, "R1 miss after reset"));

        // R3: control fields, reserved bits drop
        do_wr(8'h00, 32'h000F_5A3F);
        do_rd(8'h00, 32'h000F_5A31, "R3 ctrl readback");

        // R4 / R5: base with high bits, copy into remap
        do_wr(8'h04, 32'h1230_FFF2);
        do_rd(8'h04, 32'h1230_0002, "R4 base field mask");
        do_rd(8'h08, 32'h1230_0000, "R5 remap lo copied");
        do_rd(8'h0C, 32'h0000_0002, "R5 remap hi copied");
        do_dec(32'h1234_5678, mk(0, 0, 0, 0, "R6 base above 4G misses"));

        do_wr(8'h04, 32'h1230_0000);
        do_rd(8'h0C, 32'h0, "R5 remap hi recopied");
        do_dec(32'h1234_5678, mk(1, 4'h3, 8'h5A, 36'h0_1234_5678, "R7 identity translation"));
        do_dec(32'h1224_0000, mk(0, 0, 0, 0, "R6 outside size misses"));

        // R4 / R7: remap override
        do_wr(8'h08, 32'hABCD_1234);
        do_rd(8'h08, 32'hABCD_0000, "R4 remap lo mask");
        do_wr(8'h0C, 32'hFFFF_FFF5);
        do_rd(8'h0C, 32'h0000_0005, "R4 remap hi mask");
        do_dec(32'h1234_5678, mk(1, 4'h3, 8'h5A, 36'h5_ABC4_5678, "R7 remapped"));

        // R2 / R7: non-remappable window 10
        do_wr(8'hA0, 32'h0000_11C1);
        do_wr(8'hA4, 32'h4000_0000);
        do_rd(8'hA4, 32'h4000_0000, "R2 w10 base offset");
        do_dec(32'h4000_BEEF, mk(1, 4'hC, 8'h11, 36'h0_4000_BEEF, "R7 pass-through"));
        do_dec(32'h4001_0000, mk(0, 0, 0, 0, "R6 64K window edge"));

        // R8: window 9 overlaps window 10
        do_wr(8'h98, 32'h00FF_2271);
        do_wr(8'h9C, 32'h4000_0000);
        do_rd(8'h98, 32'h00FF_2271, "R2 w9 ctrl offset");
        do_dec(32'h4000_BEEF, mk(1, 4'h7, 8'h22, 36'h0_4000_BEEF, "R8 lower index wins"));
        do_dec(32'h4080_0000, mk(1, 4'h7, 8'h22, 36'h0_4080_0000, "R8 only w9"));

        // R10: unimplemented offsets
        do_wr(8'h80, 32'hFFFF_FFFF);
        do_rd(8'h80, 32'h0, "R10 hole read");
        do_wr(8'hF0, 32'hFFFF_FFFF);
        do_rd(8'hF0, 32'h0, "R10 past end read");
        do_wr(8'h01, 32'h0);
        do_rd(8'h00, 32'h000F_5A31, "R10 unaligned write ignored");
        do_rd(8'h02, 32'h0, "R10 unaligned read");
        do_dec(32'h4000_BEEF, mk(1, 4'h7, 8'h22, 36'h0_4000_BEEF, "R10 decode unchanged"));

        // R11: disabled windows
        do_wr(8'h98, 32'h0);
        do_dec(32'h4080_0000, mk(0, 0, 0, 0, "R11 disabled w9"));
        do_dec(32'h4000_BEEF, mk(1, 4'hC, 8'h11, 36'h0_4000_BEEF, "R11 falls to w10"));
        do_wr(8'h10, 32'h000F_5A30);
        do_wr(8'h14, 32'h5000_0000);
        do_dec(32'h5000_0010, mk(0, 0, 0, 0, "R11 base match but off"));

        // R12: write and decode in one cycle
        @(negedge clk);
        reg_wr = 1'b1; reg_off = 8'h10; reg_wdata = 32'h000F_5A31;
        dec_req = 1'b1; dec_addr = 32'h5000_0010;
        exp_q.push_back(mk(0, 0, 0, 0, "R12 decode sees old state"));
        @(negedge clk);
        reg_wr = 1'b0; dec_req = 1'b0;
        do_dec(32'h5000_0010, mk(1, 4'h3, 8'h5A, 36'h0_5000_0010, "R12 decode sees new state"));

        // R12: read and write one register in one cycle
        @(negedge clk);
        reg_rd = 1'b1; reg_wr = 1'b1; reg_off = 8'h10; reg_wdata = 32'h0;
        @(negedge clk);
        reg_rd = 1'b0; reg_wr = 1'b0;
        check32("R12 read returns old", reg_rdata, 32'h000F_5A31);
        do_rd(8'h10, 32'h0, "R12 write took effect");

        // R6 / R8 / R9: back-to-back decodes
        @(negedge clk);
        dec_req = 1'b1; dec_addr = 32'h1234_5678;
        exp_q.push_back(mk(1, 4'h3, 8'h5A, 36'h5_ABC4_5678, "R6 burst 0"));
        @(negedge clk);
        dec_addr = 32'h4000_0001;
        exp_q.push_back(mk(1, 4'hC, 8'h11, 36'h0_4000_0001, "R6 burst 1"));
        @(negedge clk);
        dec_addr = 32'h9999_0000;
        exp_q.push_back(mk(0, 0, 0, 0, "R9 burst miss"));
        @(negedge clk);
        dec_req = 1'b0;

        repeat (3) @(negedge clk);
        check32("R6 all results seen", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule